// File: doc/BRIEF.md
# Core Timebase with Periodic Interrupt

This block is a free-running timebase for a small microcontroller. It runs on the bus clock. A power-of-two prescaler advances an 8-bit counter. Each time that counter wraps, the overflow event sets an overflow flag. The same event also steps a short divider chain. A 2-bit rate field picks one of four taps on that chain: one, two, four or eight overflow periods. The selected tap sets a periodic-interrupt flag.

Software sees one 8-bit control/status register. Writes take effect at the next clock edge. The read value is combinational from the stored state. The two flags can be read but cannot be written. Each flag is cleared only by writing 1 to its own write-only strobe bit. Two enables gate the flags onto a single level-sensitive interrupt request.

The block has no streaming data path, so there is no valid/ready interface and no back-pressure. Every pin is a plain control or status signal.

Top module: `core_timer`

## Requirements
- R1: The overflow flag (read bit 7) sets at the clock edge where the 8-bit counter wraps from 0xFF to 0x00. With the prescaler dividing by 2^PRE_BITS, that edge recurs every 2^(PRE_BITS+8) clocks after reset.
- R2: The periodic flag (read bit 6) sets on the overflow events chosen by the rate field, bits 1:0. Rate 00 selects every overflow, 01 every 2nd, 10 every 4th and 11 every 8th. Counting overflow events from 1 after reset, rate r fires on the events whose number is a multiple of 2^r.
- R3: Writing bits 7:6 has no effect on either flag. A flag is cleared only by a write with its strobe bit set to 1: bit 3 clears the overflow flag and bit 2 clears the periodic flag.
- R4: When a clear strobe and a setting event for the same flag fall in the same cycle, the flag ends up set.
- R5: Bits 5 (overflow enable), 4 (periodic enable) and 1:0 (rate) read back the last value written. Bits 3:2 always read 0.
- R6: The output irq equals (overflow flag AND overflow enable) OR (periodic flag AND periodic enable). It stays high until the contributing flag is cleared or its enable is dropped.
- R7: After reset the register reads 0x03: both flags and both enables are clear and the rate is 11. irq is low.
- R8: Register writes never disturb the prescaler, the counter or the divider chain, so the event timing of R1 and R2 is unaffected by any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read value of the control/status register |
| irq | output | 1 | Combined level interrupt request |

## Verification
The bench builds the block with PRE_BITS = 2 and the 8-bit counter. This makes one overflow period 1024 clocks and the slowest periodic tap 8192 clocks. All four rate settings therefore fire several times within a short run. Writes are placed on the exact edges of overflow events to hit the simultaneous set-and-clear case for both flags. Other writes aim only at the flag bit positions, to show they are ignored.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int REG_W    = 8;
  localparam int RATE_W   = 2;
  localparam int RTI_TAPS = 1 << RATE_W;
  localparam int RTI_DIVW = RTI_TAPS - 1;
  // bit positions inside the control/status register
  localparam int B_OVF    = 7;
  localparam int B_RTI    = 6;
  localparam int B_OVFEN  = 5;
  localparam int B_RTIEN  = 4;
  localparam int B_OVFCLR = 3;
  localparam int B_RTICLR = 2;
  localparam logic [RATE_W-1:0] RATE_RESET = '1;

  typedef struct packed {
    logic              ovf_flag;
    logic              rti_flag;
    logic              ovf_en;
    logic              rti_en;
    logic [RATE_W-1:0] rate;
  } ct_state_t;
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int PRE_BITS = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [PRE_BITS-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = &pre_q;

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic ovf_evt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_evt = tick & (&cnt_q);

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == '0)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/ct_rti_chain.sv
module ct_rti_chain
  import ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_evt,
  input  logic [RATE_W-1:0] rate,
  output logic              rti_evt
);
  logic [RTI_DIVW-1:0] div_q;
  logic [RTI_TAPS-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (ovf_evt) div_q <= div_q + 1'b1;
  end

  assign tap[0] = ovf_evt;
  for (genvar k = 1; k < RTI_TAPS; k++) begin : g_tap
    assign tap[k] = ovf_evt & (&div_q[k-1:0]);
  end

  assign rti_evt = tap[rate];

  AST_RTI_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    rti_evt |-> ovf_evt); // R2
  AST_SLOW_IMPLIES_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    tap[RTI_TAPS-1] |-> (&tap)); // R2
endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             ovf_evt,
  input  logic             rti_evt,
  output ct_state_t        st
);
  logic ovf_clr, rti_clr;

  assign ovf_clr = we & wdata[B_OVFCLR];
  assign rti_clr = we & wdata[B_RTICLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.ovf_flag <= 1'b0;
      st.rti_flag <= 1'b0;
      st.ovf_en   <= 1'b0;
      st.rti_en   <= 1'b0;
      st.rate     <= RATE_RESET;
    end else begin
      // a setting event takes priority over a clear in the same cycle
      if (ovf_evt)      st.ovf_flag <= 1'b1;
      else if (ovf_clr) st.ovf_flag <= 1'b0;
      if (rti_evt)      st.rti_flag <= 1'b1;
      else if (rti_clr) st.rti_flag <= 1'b0;
      if (we) begin
        st.ovf_en <= wdata[B_OVFEN];
        st.rti_en <= wdata[B_RTIEN];
        st.rate   <= wdata[RATE_W-1:0];
      end
    end
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> st.ovf_flag); // R1
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_evt && rti_clr) |=> st.rti_flag); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st.ovf_flag && !ovf_clr) |=> st.ovf_flag); // R3
  AST_RTI_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.rti_flag && !rti_evt) |=> !st.rti_flag); // R3
endmodule

// File: rtl/core_timer.sv
module core_timer
  import ct_pkg::*;
#(
  parameter int PRE_BITS = 6,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic      tick, ovf_evt, rti_evt;
  ct_state_t st;

  ct_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  ct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ovf_evt(ovf_evt));

  ct_rti_chain u_rti (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .rate(st.rate),
    .rti_evt(rti_evt));

  ct_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .ovf_evt(ovf_evt), .rti_evt(rti_evt), .st(st));

  always_comb begin
    reg_rdata              = '0;
    reg_rdata[B_OVF]       = st.ovf_flag;
    reg_rdata[B_RTI]       = st.rti_flag;
    reg_rdata[B_OVFEN]     = st.ovf_en;
    reg_rdata[B_RTIEN]     = st.rti_en;
    reg_rdata[RATE_W-1:0]  = st.rate;
  end

  assign irq = (st.ovf_flag & st.ovf_en) | (st.rti_flag & st.rti_en);

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rdata[B_OVF] | reg_rdata[B_RTI])); // R6
  AST_STROBES_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[B_OVFCLR:B_RTICLR] == 2'b00); // R5
endmodule

// File: tb/core_timer_test.sv
module core_timer_test;
  localparam int PRE = 2;
  localparam int CW  = 8;
  localparam int OVP = 1 << (PRE + CW);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  bit       m_ovf, m_rti, m_oen, m_ren;
  bit [1:0] m_rate = 2'b11;

  core_timer #(.PRE_BITS(PRE), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_ovf = 0; m_rti = 0; m_oen = 0; m_ren = 0; m_rate = 2'b11;
    end else begin
      bit ovf_e, rti_e;
      cyc++;
      ovf_e = (cyc % OVP) == 0;
      rti_e = ovf_e && (((cyc / OVP) % (1 << m_rate)) == 0);
      if (reg_we) begin
        if (reg_wdata[3]) m_ovf = 0;
        if (reg_wdata[2]) m_rti = 0;
        m_oen  = reg_wdata[5];
        m_ren  = reg_wdata[4];
        m_rate = reg_wdata[1:0];
      end
      if (ovf_e) m_ovf = 1;
      if (rti_e) m_rti = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_irq;
      exp_irq = (m_ovf && m_oen) || (m_rti && m_ren);
      chk(reg_rdata[7] == m_ovf, "R1 overflow flag", reg_rdata[7], m_ovf);
      chk(reg_rdata[6] == m_rti, "R2 R3 R4 periodic flag", reg_rdata[6], m_rti);
      chk(reg_rdata[5:4] == {m_oen, m_ren}, "R5 enables", reg_rdata[5:4], {m_oen, m_ren});
      chk(reg_rdata[3:2] == 2'b00, "R5 strobes read zero", reg_rdata[3:2], 0);
      chk(reg_rdata[1:0] == m_rate, "R5 R8 rate field", reg_rdata[1:0], m_rate);
      chk(irq == exp_irq, "R6 irq", irq, exp_irq);
    end
  end

  task automatic wr_at(input int n, input logic [7:0] d);
    while (cyc != n - 1) @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(reg_rdata == 8'h03, "R7 reset value", reg_rdata, 8'h03);
        chk(irq == 1'b0, "R7 reset irq", irq, 0);
        rst_n = 1'b1;
        wr_at(100, 8'h33);          // both enables, rate 11
        wait_to(OVP + 5);
        chk(irq == 1'b1, "R6 overflow request", irq, 1);
        wr_at(1500, 8'hF3);         // flag bits only: ignored (R3)
        chk(reg_rdata[7] == 1'b1, "R3 flag survives write", reg_rdata[7], 1);
        wr_at(1600, 8'h3B);         // clear overflow
        chk(reg_rdata[7] == 1'b0, "R3 clear strobe", reg_rdata[7], 0);
        wr_at(2 * OVP, 8'h3B);      // clear on the setting edge (R4)
        chk(reg_rdata[7] == 1'b1, "R4 overflow set wins", reg_rdata[7], 1);
        wr_at(2100, 8'h3C);         // clear both, rate 00
        wr_at(3000, 8'h3C);
        wr_at(4200, 8'h1D);         // periodic enable only, rate 01
        wr_at(5000, 8'h1D);
        wr_at(6000, 8'h2E);         // overflow enable, rate 10
        wr_at(8 * OVP, 8'h26);      // clear periodic on its setting edge (R4)
        chk(reg_rdata[6] == 1'b1, "R4 periodic set wins", reg_rdata[6], 1);
        wr_at(9000, 8'h1F);         // rate 11, periodic enable
        wait_to(24 * OVP + 20);
        chk(irq == 1'b1, "R2 slowest tap request", irq, 1);
        wr_at(25000, 8'h0C);        // enables off
        chk(irq == 1'b0, "R6 irq dropped", irq, 0);
        wait_to(30000);
      end
      begin
        wait (cyc > 100000);
        chk(1'b0, "watchdog", cyc, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule